// File: doc/BRIEF.md
# Status Change-of-State Interrupt Unit

This block watches two 8-bit live status words and reports to a host processor when either of them has moved away from the value that the host last read. Each status word has a private snapshot. The snapshot is reloaded whenever the host reads that status word. Any mismatch between a live word and its snapshot sets a single sticky change event.

The change event is gated by a mask bit and becomes a summary interrupt bit. The summary bit drives an active-low interrupt pin. The host handles the interrupt in four steps: read the event register, which clears the event; read the status words, which returns their current values and realigns the snapshots; compare those values with its own copies; then act.

The host reaches everything through a small registered read port and a write port. The only writable register is the mask register.

Top module: `cosi_unit`

## Requirements
- R1: After reset the event bit is 0, the mask register reads 0x01 (event masked), and `int_n` is 1. Each snapshot is loaded with the live status value present during reset, so a steady status raises no event after reset.
- R2: If `sts_a` differs from its snapshot in any bit during a cycle, the event bit is 1 after the next clock edge. This holds even when the difference lasts only one cycle.
- R3: If `sts_b` differs from its snapshot in any bit during a cycle, the event bit is 1 after the next clock edge.
- R4: A read at address 0 returns the live `sts_a`, and a read at address 1 returns the live `sts_b`. The same read loads that word's snapshot, so an unchanged status word raises no further event.
- R5: A read at address 2 returns the event in bit 0, with all other bits 0. The read clears the event unless a mismatch exists in the same cycle.
- R6: A mismatch in the same cycle as an event read leaves the event set, even if the mismatch goes away on the next cycle.
- R7: A write at address 3 stores the written byte in the mask register, which reads back at address 3. Bit 0 equal to 1 blocks the event from the summary and the pin, but the event is still latched. Bit 0 equal to 0 forwards the event.
- R8: A read at address 4 returns the summary in bit 0, defined as the event AND NOT mask bit 0. A read at any address from 5 to 7 returns 0.
- R9: `int_n` goes to 0 one clock edge after the summary becomes true. It stays 0 while the summary stays true, and returns to 1 one edge after the summary clears.
- R10: `rd_data` is updated at the clock edge that samples `rd_en`. It holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sts_a | input | DW | First live status word |
| sts_b | input | DW | Second live status word |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read address |
| rd_data | output | DW | Registered read data |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address |
| wr_data | input | DW | Host write data |
| int_n | output | 1 | Active-low interrupt, registered |

## Verification
The bench drives a status change that lasts a single cycle and lands on the same edge as an event read. A design that lets the clear win over the set would lose that change, and the next event read would return 0.

It holds a status mismatch across an event read. A design that clears unconditionally would drop the interrupt while the host has not yet realigned the snapshots.

It checks that a masked event is still latched and can be read. A design that gates the event at its input would return 0 there.

It also applies reset while a status word holds a non-zero value. A design that resets the snapshots to zero would raise a spurious event right after reset.

// File: rtl/cosi_pkg.sv
package cosi_pkg;
  localparam int unsigned ADDR_STS_A = 0;
  localparam int unsigned ADDR_STS_B = 1;
  localparam int unsigned ADDR_EVT   = 2;
  localparam int unsigned ADDR_MASK  = 3;
  localparam int unsigned ADDR_SUMM  = 4;
  localparam int unsigned NUM_STS    = 2;
endpackage

// File: rtl/cosi_snap.sv
module cosi_snap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sts,
  input  logic          load,
  output logic [DW-1:0] snap,
  output logic          chg
);
  always_ff @(posedge clk) begin
    if (rst || load) snap <= sts;
  end

  assign chg = |(sts ^ snap);
endmodule

// File: rtl/cosi_evt.sv
module cosi_evt #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chg_any,
  input  logic          clr,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wd,
  output logic          evt_q,
  output logic [DW-1:0] mask_q,
  output logic          summ,
  output logic          int_n
);
  localparam logic [DW-1:0] MASK_RST = DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q  <= 1'b0;
      mask_q <= MASK_RST;
      int_n  <= 1'b1;
    end else begin
      if (chg_any)  evt_q <= 1'b1;
      else if (clr) evt_q <= 1'b0;
      if (mask_we)  mask_q <= mask_wd;
      int_n <= ~summ;
    end
  end

  assign summ = evt_q & ~mask_q[0];
endmodule

// File: rtl/cosi_unit.sv
module cosi_unit
  import cosi_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sts_a,
  input  logic [DW-1:0] sts_b,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          int_n
);
  logic [DW-1:0]      sts_v  [NUM_STS];
  logic [DW-1:0]      snap_v [NUM_STS];
  logic [NUM_STS-1:0] chg_v;
  logic               chg_any;
  logic               evt_q;
  logic               summ;
  logic [DW-1:0]      mask_q;
  logic [DW-1:0]      rd_next;

  assign sts_v[0] = sts_a;
  assign sts_v[1] = sts_b;

  for (genvar g = 0; g < NUM_STS; g++) begin : g_snap
    cosi_snap #(.DW(DW)) u_snap (
      .clk  (clk),
      .rst  (rst),
      .sts  (sts_v[g]),
      .load (rd_en && (rd_addr == AW'(g))),
      .snap (snap_v[g]),
      .chg  (chg_v[g])
    );
  end

  assign chg_any = |chg_v;

  cosi_evt #(.DW(DW)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .chg_any (chg_any),
    .clr     (rd_en && (rd_addr == AW'(ADDR_EVT))),
    .mask_we (wr_en && (wr_addr == AW'(ADDR_MASK))),
    .mask_wd (wr_data),
    .evt_q   (evt_q),
    .mask_q  (mask_q),
    .summ    (summ),
    .int_n   (int_n)
  );

  always_comb begin
    case (rd_addr)
      AW'(ADDR_STS_A): rd_next = sts_a;
      AW'(ADDR_STS_B): rd_next = sts_b;
      AW'(ADDR_EVT):   rd_next = DW'(evt_q);
      AW'(ADDR_MASK):  rd_next = mask_q;
      AW'(ADDR_SUMM):  rd_next = DW'(summ);
      default:         rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/cosi_unit_chk.sv
module cosi_unit_chk
  import cosi_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] sts_a,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          int_n,
  input logic          evt_q,
  input logic          mask_b0,
  input logic [DW-1:0] snap_a,
  input logic          chg_any
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (int_n && mask_b0 && !evt_q)); // R1
  AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (rst) chg_any |=> evt_q); // R2
  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == AW'(ADDR_STS_A)) |=> (snap_a == $past(sts_a))); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == AW'(ADDR_EVT) && !chg_any) |=> !evt_q); // R5
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst) mask_b0 |=> int_n); // R7
  AST_INT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !mask_b0) |=> !int_n); // R9
endmodule

bind cosi_unit cosi_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sts_a   (sts_a),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .int_n   (int_n),
  .evt_q   (evt_q),
  .mask_b0 (mask_q[0]),
  .snap_a  (snap_v[0]),
  .chg_any (chg_any)
);

// File: tb/cosi_unit_test.sv
module cosi_unit_test;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic [1:0] op;   // 0 idle, 1 read, 2 write
    logic [2:0] addr;
    logic [7:0] wd;
    logic [7:0] erd;
    logic       eint;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 2'd1, 3'd4, 8'h00, 8'h00, 1'b1}, // R1 R8 summary 0
    '{8'h00, 8'h00, 2'd2, 3'd3, 8'h00, 8'h00, 1'b1}, // R7 unmask, R10 hold
    '{8'h01, 8'h00, 2'd0, 3'd0, 8'h00, 8'h00, 1'b0}, // R2 change on a
    '{8'h01, 8'h00, 2'd1, 3'd2, 8'h00, 8'h01, 1'b0}, // R5 read keeps set on mismatch
    '{8'h01, 8'h00, 2'd1, 3'd0, 8'h00, 8'h01, 1'b0}, // R4 read a
    '{8'h01, 8'h00, 2'd1, 3'd2, 8'h00, 8'h01, 1'b1}, // R5 clear, R9 pin release
    '{8'h01, 8'h00, 2'd1, 3'd2, 8'h00, 8'h00, 1'b1}, // R5 cleared
    '{8'h01, 8'h80, 2'd0, 3'd0, 8'h00, 8'h00, 1'b0}, // R3 change on b
    '{8'h01, 8'h80, 2'd1, 3'd1, 8'h00, 8'h80, 1'b0}, // R4 read b
    '{8'h01, 8'h80, 2'd1, 3'd4, 8'h00, 8'h01, 1'b0}, // R8 summary 1
    '{8'h01, 8'h80, 2'd2, 3'd3, 8'h01, 8'h01, 1'b1}, // R7 mask blocks pin
    '{8'h01, 8'h80, 2'd1, 3'd2, 8'h00, 8'h01, 1'b1}, // R7 still latched
    '{8'h01, 8'h80, 2'd1, 3'd3, 8'h00, 8'h01, 1'b1}, // R7 mask readback
    '{8'h01, 8'h80, 2'd1, 3'd5, 8'h00, 8'h00, 1'b1}, // R8 unmapped
    '{8'h01, 8'h80, 2'd2, 3'd3, 8'h00, 8'h00, 1'b1}, // R7 unmask, no event
    '{8'h01, 8'h80, 2'd1, 3'd2, 8'h00, 8'h00, 1'b1}  // R4 no spurious event
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] sts_a = '0;
  logic [DW-1:0] sts_b = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          int_n;
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  cosi_unit #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .sts_a(sts_a), .sts_b(sts_b),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .int_n(int_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    sts_a = v.a; sts_b = v.b;
    rd_en = (v.op == 2'd1); wr_en = (v.op == 2'd2);
    rd_addr = v.addr; wr_addr = v.addr; wr_data = v.wd;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "int_n after reset", int_n, 1);
    rd(3'd3);
    check("R1", "mask after reset", rd_data, 8'h01);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i]);
      check("R10", $sformatf("vec %0d rd_data", i), rd_data, VEC[i].erd);
      check("R9", $sformatf("vec %0d int_n", i), int_n, VEC[i].eint);
    end
    // R6: one-cycle change on the same edge as an event read
    @(negedge clk);
    sts_a = 8'h02; rd_en = 1'b1; rd_addr = 3'd2;
    @(negedge clk);
    sts_a = 8'h01; rd_en = 1'b0;
    check("R6", "event read before change", rd_data, 8'h00);
    @(negedge clk);
    check("R9", "pin low after pulse", int_n, 0);
    rd(3'd2);
    check("R6", "event kept through read", rd_data, 8'h01);
    rd(3'd2);
    check("R5", "event cleared", rd_data, 8'h00);
    @(negedge clk);
    check("R9", "pin released", int_n, 1);
    // R2: single-cycle glitch with no read still latches
    @(negedge clk);
    sts_b = 8'h81;
    @(negedge clk);
    sts_b = 8'h80;
    rd(3'd2);
    check("R2", "glitch on b latched", rd_data, 8'h01);
    rd(3'd1);
    check("R4", "read b live", rd_data, 8'h80);
    // R1: reset with non-zero status loads snapshots
    @(negedge clk);
    sts_a = 8'h55; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "int_n after mid reset", int_n, 1);
    rd(3'd2);
    check("R1", "no event after reset", rd_data, 8'h00);
    rd(3'd3);
    check("R1", "mask after mid reset", rd_data, 8'h01);
    rd(3'd0);
    check("R4", "read a live", rd_data, 8'h55);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule